// File: doc/BRIEF.md
# SD Block Data Transfer Sequencer

This block paces the data phase of an SD host. Software programs a block length and a number of blocks, then writes a data control word. That word picks one of three transfer kinds: a busy wait, a receive from the card, or a transmit to the card. It also says whether the transfer begins on that write or waits until the command phase reports completion. While a transfer runs, the block moves one byte per clock between the card-side byte stream and the host FIFO.

It moves a byte only when both sides can take part. It counts down the bytes left in the current block and the blocks left in the transfer, and reloads the byte count at each block boundary. It raises a finish flag when the last byte has moved.

A stop bit in the data control word abandons a transfer. A status word shows the active direction, the finish event and any interrupt signalled by an SDIO card. The last two can each be routed to an interrupt line, and software clears them by writing ones. A 16-bit data/busy timeout value is also held here for the surrounding logic. The FIFO storage, the command engine and the DAT line drivers sit outside the block.

Top module: `sd_xfer_seq`

## Requirements
- R1: After reset the remaining-count output and the status word are zero, `irq` is low and no byte moves.
- R2: A data control write with mode field [13:12] set to 2 (receive) or 3 (transmit) and the matching defer bit clear starts at once. From the next cycle `remain` shows the block count (bits [11:0] of the write) in bits [23:12] and the block size in bits [11:0]. Status bit 0 is set for receive and bit 1 for transmit.
- R3: When the defer bit for the chosen mode is set (bit 18 busy, bit 19 receive, bit 20 transmit), the write only arms the sequencer. `remain` and the active flags stay unchanged until a `cmd_done` pulse, after which the counts load and the transfer runs. A `cmd_done` pulse while not armed changes nothing.
- R4: Each moved byte lowers the byte count by one. When the byte count would reach zero and more than one block remains, the block count drops by one and the byte count reloads with the block size.
- R5: In receive, a byte moves (`fifo_wr_en` and `card_rx_ack` high, `fifo_wr_data` equal to `card_rx_data`) only when `card_rx_valid` and `fifo_wr_space` are both high. Otherwise the counts hold.
- R6: In transmit, a byte moves (`fifo_rd_en` and `card_tx_valid` high, `card_tx_data` equal to `fifo_rd_data`) only when `fifo_rd_avail` and `card_tx_ready` are both high. Otherwise the counts hold.
- R7: After the last byte moves, both active flags clear, `remain` reads zero and status bit 4 (finished) sets. `irq` rises when `irq_mask` bit 0 is set.
- R8: A data control write with bit 14 set ends any transfer. The active flags clear, no finish is flagged, the counts are kept and no further byte moves.
- R9: Mode 1 (busy wait) sets status bit 2 while `card_busy` is high. The first cycle it sees `card_busy` low ends the transfer with the finish flag.
- R10: A status-clear write clears status bits among [9:3] that are written as one. Bits [2:0] are not affected.
- R11: While `sdio_en` is high and `card_irq` is high, status bit 9 sets on the next clock. `irq` rises when `irq_mask` bit 1 is set. While `sdio_en` is low the flag does not set.
- R12: The timeout value resets to 0x2000 and takes all 16 bits of a timer write.
- R13: A start with a block size or block count of zero sets the finish flag at once, shows no active flag and moves no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_we | input | 1 | Block size write strobe |
| size_wdata | input | 12 | Block length in bytes |
| ctrl_we | input | 1 | Data control write strobe |
| ctrl_wdata | input | 21 | Data control word: count [11:0], mode [13:12], stop [14], defer bits [20:18] |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 10 | Ones clear the matching status bits in [9:3] |
| timer_we | input | 1 | Timeout value write strobe |
| timer_wdata | input | 16 | New timeout value |
| irq_mask | input | 2 | Bit 0 enables finish interrupt, bit 1 enables SDIO interrupt |
| sdio_en | input | 1 | Enables SDIO interrupt detection |
| cmd_done | input | 1 | Pulse when the command phase completes |
| card_busy | input | 1 | Card signals busy |
| card_irq | input | 1 | Card interrupt level |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ack | output | 1 | Received byte taken |
| fifo_wr_space | input | 1 | FIFO can accept a byte |
| fifo_wr_en | output | 1 | Push byte into FIFO |
| fifo_wr_data | output | 8 | Byte pushed into FIFO |
| fifo_rd_avail | input | 1 | FIFO holds a byte |
| fifo_rd_en | output | 1 | Pop byte from FIFO |
| fifo_rd_data | input | 8 | Byte at the FIFO head |
| card_tx_ready | input | 1 | Card side accepts a byte |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte offered to the card |
| remain | output | 24 | Blocks left [23:12], bytes left in block [11:0] |
| status | output | 10 | Receive [0], transmit [1], busy [2], finished [4], SDIO interrupt [9] |
| timer_value | output | 16 | Data/busy timeout value |
| irq | output | 1 | Masked interrupt request |

## Verification
Register writes, including starts, stops, arming and flag clears, show on `remain` and `status` one clock edge after the strobe. The byte handshakes are combinational in the cycle the inputs allow them. The count change from a moved byte appears after the following edge, and so does the finish flag raised by the last byte. SDIO detection and busy-end also land one edge after their inputs. The bench drives every input on the falling edge. It reads combinational handshakes and registered results shortly after that falling edge, which is one whole edge after the stimulus that caused them. Each check therefore looks at exactly the cycle where its result is due.

// File: rtl/sdseq_pkg.sv
// Shared encodings for the SD data transfer sequencer.
// Assumes the block count field fits below the mode field (count width <= 12).
package sdseq_pkg;

    // Data control word layout
    localparam int CTRL_W         = 21;
    localparam int MODE_LSB       = 12;
    localparam int STOP_BIT       = 14;
    localparam int DEFER_BUSY_BIT = 18;
    localparam int DEFER_RX_BIT   = 19;
    localparam int DEFER_TX_BIT   = 20;

    // Status word layout
    localparam int STAT_W    = 10;
    localparam int STAT_RX   = 0;
    localparam int STAT_TX   = 1;
    localparam int STAT_BUSY = 2;
    localparam int STAT_DONE = 4;
    localparam int STAT_SDIO = 9;

    // Interrupt enable bits
    localparam int IRQ_DONE = 0;
    localparam int IRQ_SDIO = 1;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_BUSY = 2'd1,
        MODE_RX   = 2'd2,
        MODE_TX   = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSY,
        ST_RX,
        ST_TX
    } seq_state_e;

endpackage

// File: rtl/sdseq_counter.sv
// Byte and block down-counters for one data transfer.
// Loads both counts on a start and steps once per moved byte, reloading the
// byte count from the block size at each block boundary.
// Assumes load and step are never high together.
module sdseq_counter #(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_num,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic              step,
    output logic [SIZE_W-1:0] byte_left,
    output logic [CNT_W-1:0]  blk_left,
    output logic              last_byte
);

    localparam logic [SIZE_W-1:0] ONE_B = {{(SIZE_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  ONE_K = {{(CNT_W-1){1'b0}}, 1'b1};

    logic block_end;

    // The current byte is the last of its block.
    assign block_end = (byte_left == ONE_B);
    // The current byte is the last of the whole transfer.
    assign last_byte = block_end && (blk_left == ONE_K);

    // Count bytes within a block and blocks within the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_left <= '0;
            blk_left  <= '0;
        end else if (load) begin
            byte_left <= blk_size;
            blk_left  <= load_num;
        end else if (step) begin
            if (block_end) begin
                blk_left  <= blk_left - ONE_K;
                byte_left <= (blk_left > ONE_K) ? blk_size : '0;
            end else begin
                byte_left <= byte_left - ONE_B;
            end
        end
    end

    assert_step_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && byte_left > ONE_B) |=> (byte_left == $past(byte_left) - ONE_B))
        else $error("byte count did not decrement");

    assert_block_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && block_end && blk_left > ONE_K)
        |=> (byte_left == $past(blk_size) && blk_left == $past(blk_left) - ONE_K))
        else $error("block boundary reload wrong");

endmodule

// File: rtl/sdseq_fsm.sv
// Transfer sequencer: decodes the data control word, arms or starts a
// transfer, gates byte movement on both handshake sides and signals finish.
// Assumes cmd_done is a single-cycle pulse; a control write in the same
// cycle takes priority over it and over any byte movement.
module sdseq_fsm
    import sdseq_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cmd_done,
    input  logic              card_busy,
    input  logic              card_rx_valid,
    input  logic              fifo_wr_space,
    input  logic              fifo_rd_avail,
    input  logic              card_tx_ready,
    input  logic              last_byte,
    input  logic [SIZE_W-1:0] blk_size,
    output logic              load,
    output logic [CNT_W-1:0]  load_num,
    output logic              rx_move,
    output logic              tx_move,
    output logic              tx_offer,
    output logic              finish,
    output logic              rx_on,
    output logic              tx_on,
    output logic              busy_on
);

    seq_state_e state_q, state_d;
    xfer_mode_e mode_q, wr_mode, start_mode;
    logic [CNT_W-1:0] num_q;
    logic wr_stop, wr_defer, wr_go, go_now, go_cmd, start, empty_xfer;
    logic ctrl_unused;

    // Map a transfer mode onto its running state.
    function automatic seq_state_e run_state(input xfer_mode_e m);
        case (m)
            MODE_BUSY: run_state = ST_BUSY;
            MODE_RX:   run_state = ST_RX;
            MODE_TX:   run_state = ST_TX;
            default:   run_state = ST_IDLE;
        endcase
    endfunction

    assign wr_mode     = xfer_mode_e'(ctrl_wdata[MODE_LSB +: 2]);
    assign wr_stop     = ctrl_wdata[STOP_BIT];
    assign ctrl_unused = ^ctrl_wdata[DEFER_BUSY_BIT-1:STOP_BIT+1];

    // Pick the defer bit belonging to the written mode.
    always_comb begin
        case (wr_mode)
            MODE_BUSY: wr_defer = ctrl_wdata[DEFER_BUSY_BIT];
            MODE_RX:   wr_defer = ctrl_wdata[DEFER_RX_BIT];
            MODE_TX:   wr_defer = ctrl_wdata[DEFER_TX_BIT];
            default:   wr_defer = 1'b0;
        endcase
    end

    assign wr_go      = ctrl_we && !wr_stop && (wr_mode != MODE_NONE);
    assign go_now     = wr_go && !wr_defer;
    assign go_cmd     = !ctrl_we && (state_q == ST_ARMED) && cmd_done;
    assign start      = go_now || go_cmd;
    assign start_mode = ctrl_we ? wr_mode : mode_q;
    assign load_num   = ctrl_we ? ctrl_wdata[CNT_W-1:0] : num_q;
    assign empty_xfer = (load_num == '0) || (blk_size == '0);
    assign load       = start;

    // Byte handshakes; a control write cycle moves nothing.
    assign rx_move  = (state_q == ST_RX) && !ctrl_we && card_rx_valid && fifo_wr_space;
    assign tx_offer = (state_q == ST_TX) && !ctrl_we && fifo_rd_avail;
    assign tx_move  = tx_offer && card_tx_ready;

    // Finish on an empty start, the final byte, or the end of busy.
    assign finish = (start && empty_xfer)
                 || ((rx_move || tx_move) && last_byte)
                 || ((state_q == ST_BUSY) && !ctrl_we && !card_busy);

    assign rx_on   = (state_q == ST_RX);
    assign tx_on   = (state_q == ST_TX);
    assign busy_on = (state_q == ST_BUSY);

    // Next-state selection: control writes first, then command, then finish.
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            if (go_now)
                state_d = empty_xfer ? ST_IDLE : run_state(start_mode);
            else if (wr_go)
                state_d = ST_ARMED;
            else
                state_d = ST_IDLE;
        end else if (go_cmd) begin
            state_d = empty_xfer ? ST_IDLE : run_state(start_mode);
        end else if (finish) begin
            state_d = ST_IDLE;
        end
    end

    // Sequencer state and the shadow of the last control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_NONE;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ctrl_we) begin
                mode_q <= wr_mode;
                num_q  <= ctrl_wdata[CNT_W-1:0];
            end
        end
    end

    assert_one_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_on, tx_on, busy_on}))
        else $error("more than one transfer kind active");

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_stop) |=> !(rx_on || tx_on || busy_on))
        else $error("stop did not end transfer");

    assert_armed_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !cmd_done && !ctrl_we) |=> (state_q == ST_ARMED))
        else $error("armed transfer left without command");

endmodule

// File: rtl/sdseq_flags.sv
// Status flags, interrupt request, block size and timeout value.
// Sticky flags set with priority over a software clear in the same cycle;
// live activity bits come straight from the sequencer and cannot be cleared.
module sdseq_flags
    import sdseq_pkg::*;
#(
    parameter int                SIZE_W    = 12,
    parameter int                TIMER_W   = 16,
    parameter logic [TIMER_W-1:0] TIMER_RST = 16'h2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               finish,
    input  logic               rx_on,
    input  logic               tx_on,
    input  logic               busy_on,
    input  logic               sdio_en,
    input  logic               card_irq,
    input  logic               clr_we,
    input  logic [STAT_W-1:0]  clr_data,
    input  logic [1:0]         irq_mask,
    input  logic               size_we,
    input  logic [SIZE_W-1:0]  size_wdata,
    input  logic               timer_we,
    input  logic [TIMER_W-1:0] timer_wdata,
    output logic [STAT_W-1:0]  status,
    output logic               irq,
    output logic [SIZE_W-1:0]  blk_size,
    output logic [TIMER_W-1:0] timer_value
);

    logic done_q, sdio_q, sdio_hit;
    logic clr_unused;

    assign sdio_hit   = sdio_en && card_irq;
    assign clr_unused = ^{clr_data[STAT_SDIO-1:STAT_DONE+1], clr_data[STAT_DONE-1:0]};

    // Sticky finish and SDIO flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            sdio_q <= 1'b0;
        end else begin
            if (finish)
                done_q <= 1'b1;
            else if (clr_we && clr_data[STAT_DONE])
                done_q <= 1'b0;
            if (sdio_hit)
                sdio_q <= 1'b1;
            else if (clr_we && clr_data[STAT_SDIO])
                sdio_q <= 1'b0;
        end
    end

    // Block size and timeout registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_size    <= '0;
            timer_value <= TIMER_RST;
        end else begin
            if (size_we)  blk_size    <= size_wdata;
            if (timer_we) timer_value <= timer_wdata;
        end
    end

    // Assemble the status word.
    always_comb begin
        status            = '0;
        status[STAT_RX]   = rx_on;
        status[STAT_TX]   = tx_on;
        status[STAT_BUSY] = busy_on;
        status[STAT_DONE] = done_q;
        status[STAT_SDIO] = sdio_q;
    end

    assign irq = (done_q && irq_mask[IRQ_DONE]) || (sdio_q && irq_mask[IRQ_SDIO]);

    assert_finish_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> status[STAT_DONE])
        else $error("finish not flagged");

    assert_sdio_detect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_hit |=> status[STAT_SDIO])
        else $error("sdio interrupt not detected");

    assert_sdio_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdio_hit && !status[STAT_SDIO]) |=> !status[STAT_SDIO])
        else $error("sdio flag set without cause");

    assert_timer_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_we |=> $stable(timer_value))
        else $error("timer changed without write");

endmodule

// File: rtl/sd_xfer_seq.sv
// Top of the SD data transfer sequencer: wires the control sequencer, the
// byte/block counters and the status flags, and passes bytes between the
// card stream and the FIFO without an intermediate register.
module sd_xfer_seq
    import sdseq_pkg::*;
#(
    parameter int                 SIZE_W    = 12,
    parameter int                 CNT_W     = 12,
    parameter int                 BYTE_W    = 8,
    parameter int                 TIMER_W   = 16,
    parameter logic [TIMER_W-1:0] TIMER_RST = 16'h2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    size_we,
    input  logic [SIZE_W-1:0]       size_wdata,
    input  logic                    ctrl_we,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    input  logic                    stat_clr_we,
    input  logic [STAT_W-1:0]       stat_clr_data,
    input  logic                    timer_we,
    input  logic [TIMER_W-1:0]      timer_wdata,
    input  logic [1:0]              irq_mask,
    input  logic                    sdio_en,
    input  logic                    cmd_done,
    input  logic                    card_busy,
    input  logic                    card_irq,
    input  logic                    card_rx_valid,
    input  logic [BYTE_W-1:0]       card_rx_data,
    output logic                    card_rx_ack,
    input  logic                    fifo_wr_space,
    output logic                    fifo_wr_en,
    output logic [BYTE_W-1:0]       fifo_wr_data,
    input  logic                    fifo_rd_avail,
    output logic                    fifo_rd_en,
    input  logic [BYTE_W-1:0]       fifo_rd_data,
    input  logic                    card_tx_ready,
    output logic                    card_tx_valid,
    output logic [BYTE_W-1:0]       card_tx_data,
    output logic [SIZE_W+CNT_W-1:0] remain,
    output logic [STAT_W-1:0]       status,
    output logic [TIMER_W-1:0]      timer_value,
    output logic                    irq
);

    logic              load, rx_move, tx_move, tx_offer, finish;
    logic              rx_on, tx_on, busy_on, last_byte;
    logic [CNT_W-1:0]  load_num, blk_left;
    logic [SIZE_W-1:0] byte_left, blk_size;

    sdseq_fsm #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cmd_done(cmd_done), .card_busy(card_busy),
        .card_rx_valid(card_rx_valid), .fifo_wr_space(fifo_wr_space),
        .fifo_rd_avail(fifo_rd_avail), .card_tx_ready(card_tx_ready),
        .last_byte(last_byte), .blk_size(blk_size),
        .load(load), .load_num(load_num),
        .rx_move(rx_move), .tx_move(tx_move), .tx_offer(tx_offer),
        .finish(finish), .rx_on(rx_on), .tx_on(tx_on), .busy_on(busy_on)
    );

    sdseq_counter #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_num(load_num), .blk_size(blk_size),
        .step(rx_move || tx_move),
        .byte_left(byte_left), .blk_left(blk_left), .last_byte(last_byte)
    );

    sdseq_flags #(.SIZE_W(SIZE_W), .TIMER_W(TIMER_W), .TIMER_RST(TIMER_RST)) flags_i (
        .clk(clk), .rst_n(rst_n),
        .finish(finish), .rx_on(rx_on), .tx_on(tx_on), .busy_on(busy_on),
        .sdio_en(sdio_en), .card_irq(card_irq),
        .clr_we(stat_clr_we), .clr_data(stat_clr_data), .irq_mask(irq_mask),
        .size_we(size_we), .size_wdata(size_wdata),
        .timer_we(timer_we), .timer_wdata(timer_wdata),
        .status(status), .irq(irq), .blk_size(blk_size), .timer_value(timer_value)
    );

    // Byte paths pass straight through between card and FIFO.
    assign card_rx_ack   = rx_move;
    assign fifo_wr_en    = rx_move;
    assign fifo_wr_data  = card_rx_data;
    assign card_tx_valid = tx_offer;
    assign fifo_rd_en    = tx_move;
    assign card_tx_data  = fifo_rd_data;
    assign remain        = {blk_left, byte_left};

    assert_rx_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (fifo_wr_space && card_rx_valid && status[STAT_RX]))
        else $error("receive byte moved without handshake");

    assert_tx_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> (fifo_rd_avail && card_tx_ready && status[STAT_TX]))
        else $error("transmit byte moved without handshake");

    assert_move_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en || fifo_rd_en) |=> (remain != $past(remain)))
        else $error("moved byte not counted");

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_wr_en && !fifo_rd_en && !ctrl_we && !cmd_done) |=> $stable(remain))
        else $error("count changed without a byte");

endmodule

// File: tb/sd_xfer_seq_tb.sv
module sd_xfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        size_we, ctrl_we, stat_clr_we, timer_we;
    logic [11:0] size_wdata;
    logic [20:0] ctrl_wdata;
    logic [9:0]  stat_clr_data;
    logic [15:0] timer_wdata;
    logic [1:0]  irq_mask;
    logic        sdio_en, cmd_done, card_busy, card_irq;
    logic        card_rx_valid, card_rx_ack, fifo_wr_space, fifo_wr_en;
    logic [7:0]  card_rx_data, fifo_wr_data, fifo_rd_data, card_tx_data;
    logic        fifo_rd_avail, fifo_rd_en, card_tx_ready, card_tx_valid;
    logic [23:0] remain;
    logic [9:0]  status;
    logic [15:0] timer_value;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int n_rx = 0;
    int n_tx = 0;

    always #4 clk = ~clk;

    sd_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .size_we(size_we), .size_wdata(size_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .timer_we(timer_we), .timer_wdata(timer_wdata),
        .irq_mask(irq_mask), .sdio_en(sdio_en), .cmd_done(cmd_done),
        .card_busy(card_busy), .card_irq(card_irq),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ack(card_rx_ack),
        .fifo_wr_space(fifo_wr_space), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_rd_avail(fifo_rd_avail), .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
        .card_tx_ready(card_tx_ready), .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .remain(remain), .status(status), .timer_value(timer_value), .irq(irq)
    );

    // Vectors: {mode[1:0], block count[11:0], block size[11:0]}
    localparam logic [25:0] VECS [5] = '{
        {2'd2, 12'd2, 12'd4},
        {2'd3, 12'd3, 12'd3},
        {2'd2, 12'd1, 12'd1},
        {2'd3, 12'd1, 12'd5},
        {2'd2, 12'd4, 12'd2}
    };

    // Count byte moves between falling and rising edge.
    always begin
        @(negedge clk);
        #2;
        if (fifo_wr_en) n_rx++;
        if (fifo_rd_en) n_tx++;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [20:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0; #1;
    endtask

    task automatic wr_size(input logic [11:0] v);
        @(negedge clk); size_we = 1'b1; size_wdata = v;
        @(negedge clk); size_we = 1'b0; #1;
    endtask

    task automatic wr_clr(input logic [9:0] v);
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_data = v;
        @(negedge clk); stat_clr_we = 1'b0; #1;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_src(input logic v);
        card_rx_valid = v; fifo_wr_space = v; fifo_rd_avail = v; card_tx_ready = v;
    endtask

    initial begin
        rst_n = 1'b0;
        size_we = 0; ctrl_we = 0; stat_clr_we = 0; timer_we = 0;
        size_wdata = '0; ctrl_wdata = '0; stat_clr_data = '0; timer_wdata = '0;
        irq_mask = 2'b01; sdio_en = 0; cmd_done = 0; card_busy = 0; card_irq = 0;
        card_rx_data = 8'h3C; fifo_rd_data = 8'hA5;
        set_src(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 / R12 reset state
        chk("R1 remain", remain, 0);
        chk("R1 status", status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 no move", fifo_wr_en | fifo_rd_en, 0);
        chk("R12 timer reset", timer_value, 16'h2000);

        // R12 timer write
        @(negedge clk); timer_we = 1'b1; timer_wdata = 16'hBEEF;
        @(negedge clk); timer_we = 1'b0; #1;
        chk("R12 timer write", timer_value, 16'hBEEF);

        // Table walk: R2 start, R4 counting, R7 finish
        set_src(1'b1);
        for (int i = 0; i < 5; i++) begin
            logic [1:0]  m;
            logic [11:0] nb, sz;
            m  = VECS[i][25:24];
            nb = VECS[i][23:12];
            sz = VECS[i][11:0];
            wr_size(sz);
            n_rx = 0; n_tx = 0;
            wr_ctrl({7'd0, m, nb});
            chk("R2 counts loaded", remain, {nb, sz});
            chk("R2 active flag", status[1:0], (m == 2'd2) ? 2'b01 : 2'b10);
            for (int c = 0; c < 200; c++) begin
                @(negedge clk); #1;
                if (status[4]) break;
            end
            chk("R4 bytes moved", (m == 2'd2) ? n_rx : n_tx, sz * nb);
            chk("R7 remain zero", remain, 0);
            chk("R7 flags", status, 10'h010);
            chk("R7 irq", irq, 1);
            wr_clr(10'h010);
            chk("R10 done cleared", status[4], 0);
        end
        set_src(1'b0);

        // R4 stepwise reload, R5 handshake and stall
        wr_size(12'd2);
        wr_ctrl({7'd0, 2'd2, 12'd3});
        chk("R4 load", remain, 24'h003002);
        card_rx_valid = 1'b1;
        idle_cycles(3);
        chk("R5 stall no move", fifo_wr_en, 0);
        chk("R5 stall counts", remain, 24'h003002);
        @(negedge clk); fifo_wr_space = 1'b1; #1;
        chk("R5 ack", {fifo_wr_en, card_rx_ack}, 2'b11);
        chk("R5 data", fifo_wr_data, 8'h3C);
        @(negedge clk); fifo_wr_space = 1'b0; #1;
        chk("R4 decrement", remain, 24'h003001);
        @(negedge clk); fifo_wr_space = 1'b1;
        @(negedge clk); fifo_wr_space = 1'b0; #1;
        chk("R4 block reload", remain, 24'h002002);

        // R10 low bits cannot be cleared
        wr_clr(10'h007);
        chk("R10 live bit kept", status[0], 1);

        // R8 stop keeps counts and halts movement
        wr_ctrl(21'h004000);
        chk("R8 inactive", status[2:0], 0);
        chk("R8 no finish", status[4], 0);
        chk("R8 counts kept", remain, 24'h002002);
        fifo_wr_space = 1'b1;
        #1;
        chk("R8 no move", fifo_wr_en, 0);
        idle_cycles(2);
        chk("R8 counts still", remain, 24'h002002);
        set_src(1'b0);

        // R6 transmit stall and handshake
        wr_size(12'd3);
        wr_ctrl({7'd0, 2'd3, 12'd1});
        card_tx_ready = 1'b1;
        idle_cycles(3);
        chk("R6 stall offer", {card_tx_valid, fifo_rd_en}, 0);
        chk("R6 stall counts", remain, 24'h001003);
        @(negedge clk); fifo_rd_avail = 1'b1; #1;
        chk("R6 pop", {card_tx_valid, fifo_rd_en}, 2'b11);
        chk("R6 data", card_tx_data, 8'hA5);
        @(negedge clk); fifo_rd_avail = 1'b0; #1;
        chk("R6 decrement", remain, 24'h001002);
        wr_ctrl(21'h004000);
        set_src(1'b0);

        // R3 deferred start
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0; #1;
        chk("R3 idle cmd ignored", remain, 24'h001002);
        chk("R3 idle cmd status", status, 0);
        wr_ctrl(21'h082000 | 21'd2);
        chk("R3 armed not active", status[0], 0);
        chk("R3 armed counts", remain, 24'h001002);
        idle_cycles(2);
        chk("R3 still waiting", status[0], 0);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0; #1;
        chk("R3 started", status[0], 1);
        chk("R3 loaded", remain, 24'h002003);
        wr_ctrl(21'h004000);

        // R9 busy wait
        card_busy = 1'b1;
        wr_ctrl({7'd0, 2'd1, 12'd1});
        chk("R9 busy flag", status[2], 1);
        idle_cycles(3);
        chk("R9 busy held", status[4:2], 3'b001);
        @(negedge clk); card_busy = 1'b0;
        @(negedge clk); #1;
        chk("R9 finished", status[4:2], 3'b100);
        wr_clr(10'h010);

        // R13 zero-length start
        wr_size(12'd0);
        n_rx = 0;
        set_src(1'b1);
        wr_ctrl({7'd0, 2'd2, 12'd5});
        chk("R13 finish", status[4], 1);
        chk("R13 inactive", status[1:0], 0);
        idle_cycles(2);
        chk("R13 no move", n_rx, 0);
        set_src(1'b0);
        wr_clr(10'h010);

        // R11 SDIO interrupt detection
        irq_mask = 2'b10;
        card_irq = 1'b1;
        idle_cycles(2);
        chk("R11 disabled", status[9], 0);
        @(negedge clk); sdio_en = 1'b1;
        @(negedge clk); #1;
        chk("R11 detected", status[9], 1);
        chk("R11 irq", irq, 1);
        card_irq = 1'b0; sdio_en = 1'b0;
        wr_clr(10'h3F8);
        chk("R10 sdio cleared", status[9], 0);
        chk("R10 irq low", irq, 0);

        summary();
        $finish;
    end

endmodule